// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block is an in-order queue for store-type operations that sits between a load/store unit and a data cache write port. Every store-type operation is accepted on a valid/ready input stream: plain stores, alternate-space stores, atomic operations, full memory barriers and store barriers. Each queued entry describes one aligned 16-byte block. It holds the block address, a 16-bit lane mask, 128 data bits, a cacheable flag, a side-effect flag and an operation kind.

When the rules allow it, a plain store folds into the most recently queued entry. This cuts the number of cache writes without changing the bytes that finally reach memory. Stores with the side-effect attribute, atomics and barriers always take an entry of their own. This keeps I/O accesses strongly ordered.

Entries leave from the head on a valid/ready output stream. The head stays stable until it is taken. An `empty` pin lets a barrier wait until every earlier store has drained.

Back-pressure on input: `in_ready` is low only when all entries are occupied and the offered operation cannot fold into the newest entry. `in_ready` may therefore depend on the offered fields. An operation is taken on a cycle where `in_valid` and `in_ready` are both high.

Back-pressure on output: while `out_valid` is high and `out_ready` is low, every output field stays stable. The head entry leaves on a cycle where both are high.

Top module: `wcsb_top`

## Requirements
- R1: While reset (`rst_n` low) is applied and just after it, `empty`=1, `out_valid`=0 and `in_ready`=1.
- R2: Operations leave in the order they were accepted. `in_kind` is encoded as 0 = plain store, 1 = alternate-space store, 2 = atomic, 3 = full barrier, 4 = store barrier. A plain store folds only into an entry of the same kind. An alternate-space store likewise folds only into an entry of the same kind.
- R3: A fold ORs the lane mask into the entry. Lane i is data bits [8i+7:8i] at byte address block+i. On an overlapping lane, the newer data replaces the older data. A fold takes no new entry.
- R4: A cacheable store never folds into a noncacheable entry, and the reverse also holds.
- R5: A store with `in_side_effect`=1 never folds into an entry. No store ever folds into an entry whose side-effect flag is set.
- R6: Barriers and atomics always take their own entry. Nothing folds into them. A barrier entry drains with address, lane mask, data and both flags all zero.
- R7: A store folds only into the newest entry, and only when it targets the same aligned 16-byte block. `in_addr[3:0]` is ignored.
- R8: The entry at the head is closed to folding. With exactly one entry queued, a new store always takes a new entry.
- R9: With 8 entries queued, `in_ready` is 0 for an operation that cannot fold and 1 for one that can fold into the newest entry.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid` and all output fields hold their values.
- R11: `empty` is 1 exactly when no entries are queued. `out_valid` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Offered operation is valid |
| in_ready | output | 1 | Buffer takes the offered operation |
| in_kind | input | 3 | Operation kind (see R2) |
| in_addr | input | 32 | Byte address; bits [3:0] ignored |
| in_be | input | 16 | Lane mask within the block |
| in_data | input | 128 | Lane-positioned store data |
| in_cacheable | input | 1 | Cacheable attribute |
| in_side_effect | input | 1 | Side-effect attribute |
| out_valid | output | 1 | Head entry valid |
| out_ready | input | 1 | Cache write port takes the head |
| out_addr | output | 32 | Aligned block address of head |
| out_be | output | 16 | Head lane mask |
| out_data | output | 128 | Head data |
| out_kind | output | 3 | Head kind |
| out_cacheable | output | 1 | Head cacheable flag |
| out_side_effect | output | 1 | Head side-effect flag |
| empty | output | 1 | No entries queued |

## Verification
A wrong fold decision shows up at the output as an entry count that differs from the expected one. It also shows up as a lane mask or data word that differs when that entry reaches the head. With a stalled port this can be many cycles after the faulty cycle.

A wrong occupancy count appears at once, either on `in_ready` when the buffer nears full or on `empty`. A write into the head while it is stalled breaks the stability of the output fields on the very next cycle.

// File: rtl/wcsb_pkg.sv
package wcsb_pkg;
  localparam int ADDR_W = 32;
  localparam int LANES  = 16;
  localparam int DATA_W = LANES * 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [2:0] {
    K_STORE  = 3'd0,
    K_ALT    = 3'd1,
    K_ATOMIC = 3'd2,
    K_MEMBAR = 3'd3,
    K_STBAR  = 3'd4
  } kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] blk;
    logic [LANES-1:0]  be;
    logic [DATA_W-1:0] data;
    logic              cacheable;
    logic              side_eff;
    kind_e             kind;
  } entry_t;

  function automatic logic is_plain(kind_e k);
    return (k == K_STORE) || (k == K_ALT);
  endfunction

  function automatic logic is_barrier(kind_e k);
    return (k == K_MEMBAR) || (k == K_STBAR);
  endfunction
endpackage

// File: rtl/wcsb_merge_ctl.sv
module wcsb_merge_ctl
  import wcsb_pkg::*;
(
  input  logic              tail_open,
  input  entry_t            tail_ent,
  input  kind_e             in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_be,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_cacheable,
  input  logic              in_side_effect,
  output logic              merge_hit,
  output entry_t            new_ent,
  output entry_t            merged_ent
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << OFF_W) - 1);

  logic [ADDR_W-1:0] in_blk;
  logic [DATA_W-1:0] mix_data;

  assign in_blk = in_addr & ~OFF_MASK;

  // newer bytes win on every lane the incoming store enables
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mix_data[g*8 +: 8] = in_be[g] ? in_data[g*8 +: 8] : tail_ent.data[g*8 +: 8];
  end

  always_comb begin
    merge_hit = tail_open
             && is_plain(in_kind)
             && (in_kind == tail_ent.kind)
             && !in_side_effect
             && !tail_ent.side_eff
             && (in_cacheable == tail_ent.cacheable)
             && (in_blk == tail_ent.blk);

    if (is_barrier(in_kind)) begin
      new_ent      = '0;
      new_ent.kind = in_kind;
    end else begin
      new_ent.blk       = in_blk;
      new_ent.be        = in_be;
      new_ent.data      = in_data;
      new_ent.cacheable = in_cacheable;
      new_ent.side_eff  = in_side_effect;
      new_ent.kind      = in_kind;
    end

    merged_ent      = tail_ent;
    merged_ent.be   = tail_ent.be | in_be;
    merged_ent.data = mix_data;
  end
endmodule

// File: rtl/wcsb_ring.sv
module wcsb_ring
  import wcsb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  entry_t        push_ent,
  input  logic          merge_wr,
  input  entry_t        merge_ent,
  input  logic          pop,
  output entry_t        head_ent,
  output entry_t        tail_ent,
  output logic [CW-1:0] count
);
  entry_t        mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, tail_idx;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign tail_idx = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - PW'(1);
  assign head_ent = mem[rd_ptr];
  assign tail_ent = mem[tail_idx];

  always_ff @(posedge clk) begin
    if (push)     mem[wr_ptr]   <= push_ent;
    if (merge_wr) mem[tail_idx] <= merge_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_no_push_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != CW'(DEPTH)));
endmodule

// File: rtl/wcsb_top.sv
module wcsb_top
  import wcsb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_be,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_cacheable,
  input  logic              in_side_effect,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LANES-1:0]  out_be,
  output logic [DATA_W-1:0] out_data,
  output logic [2:0]        out_kind,
  output logic              out_cacheable,
  output logic              out_side_effect,
  output logic              empty
);
  entry_t        head_ent, tail_ent, new_ent, merged_ent;
  logic [CW-1:0] count;
  logic          merge_hit, tail_open, full, in_fire, push, merge_wr, pop;

  assign tail_open = count >= CW'(2);   // head is closed to folding
  assign full      = count == CW'(DEPTH);
  assign in_ready  = !full || merge_hit;
  assign in_fire   = in_valid && in_ready;
  assign push      = in_fire && !merge_hit;
  assign merge_wr  = in_fire && merge_hit;
  assign empty     = count == '0;
  assign out_valid = !empty;
  assign pop       = out_valid && out_ready;

  wcsb_merge_ctl u_ctl (
    .tail_open      (tail_open),
    .tail_ent       (tail_ent),
    .in_kind        (kind_e'(in_kind)),
    .in_addr        (in_addr),
    .in_be          (in_be),
    .in_data        (in_data),
    .in_cacheable   (in_cacheable),
    .in_side_effect (in_side_effect),
    .merge_hit      (merge_hit),
    .new_ent        (new_ent),
    .merged_ent     (merged_ent)
  );

  wcsb_ring #(.DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_ent  (new_ent),
    .merge_wr  (merge_wr),
    .merge_ent (merged_ent),
    .pop       (pop),
    .head_ent  (head_ent),
    .tail_ent  (tail_ent),
    .count     (count)
  );

  assign out_addr        = head_ent.blk;
  assign out_be          = head_ent.be;
  assign out_data        = head_ent.data;
  assign out_kind        = head_ent.kind;
  assign out_cacheable   = head_ent.cacheable;
  assign out_side_effect = head_ent.side_eff;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(head_ent)));

  assert_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && empty) |=> !empty);

  assert_fold_no_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    merge_wr |=> (count == $past(count) - CW'($past(pop))));
endmodule

// File: tb/wcsb_top_tb.sv
module wcsb_top_tb_top;
  import wcsb_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid, in_ready, in_cacheable, in_side_effect;
  logic [2:0]        in_kind, out_kind;
  logic [ADDR_W-1:0] in_addr, out_addr;
  logic [LANES-1:0]  in_be, out_be;
  logic [DATA_W-1:0] in_data, out_data;
  logic              out_valid, out_ready, out_cacheable, out_side_effect, empty;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  entry_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wcsb_top #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(bit ok, string tag, string what, logic [255:0] act, logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] blk_of(logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic bit model_fold();
    entry_t t;
    if (q.size() < 2) return 0;
    t = q[$];
    return (in_kind == 3'd0 || in_kind == 3'd1) && (in_kind == 3'(t.kind))
        && !in_side_effect && !t.side_eff && (in_cacheable == t.cacheable)
        && (blk_of(in_addr) == t.blk);
  endfunction

  // one cycle: inputs already set after a falling edge
  task automatic cyc(string tag);
    bit fold, rdy, fire, take;
    entry_t e;
    #1;
    chk(out_valid == (q.size() != 0), tag, "out_valid", 256'(out_valid), 256'(q.size() != 0));
    chk(empty == (q.size() == 0), tag, "empty R11", 256'(empty), 256'(q.size() == 0));
    if (q.size() != 0)
      chk({out_addr, out_be, out_data, out_cacheable, out_side_effect, out_kind} == q[0],
          tag, "head entry", 256'({out_addr, out_be, out_data, out_cacheable, out_side_effect, out_kind}),
          256'(q[0]));
    fold = model_fold();
    rdy  = (q.size() < DEPTH) || fold;
    chk(in_ready == rdy, tag, "in_ready", 256'(in_ready), 256'(rdy));
    fire = in_valid && rdy;
    take = out_ready && (q.size() != 0);
    @(posedge clk);
    if (fire) begin
      if (fold) begin
        e = q[$];
        for (int i = 0; i < LANES; i++)
          if (in_be[i]) e.data[i*8 +: 8] = in_data[i*8 +: 8];
        e.be = e.be | in_be;
        q[$] = e;
      end else begin
        e = '0;
        e.kind = kind_e'(in_kind);
        if (in_kind < 3'd3) begin
          e.blk = blk_of(in_addr); e.be = in_be; e.data = in_data;
          e.cacheable = in_cacheable; e.side_eff = in_side_effect;
        end
        q.push_back(e);
      end
    end
    if (take) void'(q.pop_front());
    @(negedge clk);
  endtask

  task automatic op(logic [2:0] k, logic [ADDR_W-1:0] a, logic [LANES-1:0] be,
                    logic c, logic se, string tag);
    in_valid = 1; in_kind = k; in_addr = a; in_be = be; in_cacheable = c; in_side_effect = se;
    for (int i = 0; i < LANES; i++) in_data[i*8 +: 8] = 8'($urandom);
    cyc(tag);
    in_valid = 0;
  endtask

  task automatic drain(string tag);
    out_ready = 1; in_valid = 0;
    for (int i = 0; i < DEPTH + 3; i++) cyc(tag);
    out_ready = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 0; in_valid = 0; in_kind = 0; in_addr = 0; in_be = 0; in_data = 0;
    in_cacheable = 0; in_side_effect = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(empty == 1 && out_valid == 0 && in_ready == 1, "R1", "reset outputs",
        256'({empty, out_valid, in_ready}), 256'(3'b101));
    rst_n = 1;
    @(negedge clk);
    cyc("R1");

    // R3 R8: head closed, then fold with overlap
    op(0, 32'h100, 16'h000F, 1, 0, "R8");
    op(0, 32'h104, 16'h00F0, 1, 0, "R8");
    op(0, 32'h10C, 16'h0F0F, 1, 0, "R3");
    op(0, 32'h108, 16'hF000, 1, 0, "R3");
    drain("R3");
    // R4 cacheability
    op(0, 32'h900, 16'h1, 1, 0, "R4");
    op(0, 32'h200, 16'h1, 1, 0, "R4");
    op(0, 32'h200, 16'h2, 0, 0, "R4");
    op(0, 32'h200, 16'h4, 0, 0, "R4");
    drain("R4");
    // R5 side effect
    op(0, 32'h900, 16'h1, 0, 0, "R5");
    op(0, 32'h300, 16'h1, 0, 1, "R5");
    op(0, 32'h300, 16'h2, 0, 0, "R5");
    op(0, 32'h300, 16'h4, 0, 1, "R5");
    op(0, 32'h300, 16'h8, 0, 1, "R5");
    drain("R5");
    // R6 barriers and atomics
    op(0, 32'h900, 16'h1, 1, 0, "R6");
    op(0, 32'h400, 16'h1, 1, 0, "R6");
    op(3, 32'h400, 16'hFFFF, 1, 0, "R6");
    op(0, 32'h400, 16'h2, 1, 0, "R6");
    op(4, 32'h404, 16'h3, 0, 1, "R6");
    op(2, 32'h400, 16'h4, 1, 0, "R6");
    op(2, 32'h400, 16'h8, 1, 0, "R6");
    op(0, 32'h400, 16'h10, 1, 0, "R6");
    drain("R6");
    // R7 newest only, same block only
    op(0, 32'h900, 16'h1, 1, 0, "R7");
    op(0, 32'h500, 16'h1, 1, 0, "R7");
    op(0, 32'h600, 16'h1, 1, 0, "R7");
    op(0, 32'h50F, 16'h2, 1, 0, "R7");
    drain("R7");
    // R2 kinds in order, alt vs plain
    op(1, 32'h700, 16'h1, 1, 0, "R2");
    op(1, 32'h700, 16'h2, 1, 0, "R2");
    op(1, 32'h700, 16'h4, 1, 0, "R2");
    op(0, 32'h700, 16'h8, 1, 0, "R2");
    drain("R2");
    // R9 full
    for (int i = 0; i < DEPTH; i++) op(0, 32'(32'h1000 + i * 16), 16'h1, 1, 0, "R9");
    op(0, 32'h2000, 16'h1, 1, 0, "R9");
    op(0, 32'(32'h1000 + (DEPTH - 1) * 16), 16'h80, 1, 0, "R9");
    op(3, 32'h0, 16'h0, 0, 0, "R9");
    drain("R9");

    // random mix, R10 stalls included
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] k;
      int r = $urandom_range(0, 15);
      k = (r < 9) ? 3'd0 : (r < 12) ? 3'd1 : (r < 13) ? 3'd2 : (r < 14) ? 3'd3 : 3'd4;
      out_ready = ((n / 64) % 3 == 1) ? 1'b0 : 1'($urandom_range(0, 2) != 0);
      if ($urandom_range(0, 3) != 0)
        op(k, 32'(32'h8000 + $urandom_range(0, 3) * 16 + $urandom_range(0, 15)),
           16'($urandom), 1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
           "R2 R3 R10 random");
      else
        cyc("R10 R11 random");
    end
    drain("R11");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule